// File: doc/BRIEF.md
# Two-Level Frame Priority Classifier and Weighted Queue Scheduler

This block gives each received frame one of two priority levels and then decides, each time an egress port can send, whether the high or the low queue of that port supplies the next frame. Three sources can each mark a frame high, and each is enabled on its own. The first is the ingress port number, compared against a selectable range of low-numbered ports. The second is the user-priority field of a VLAN tag. The third is the 6-bit differentiated-services codepoint of an IPv4 or IPv6 header. A frame is high when any enabled source marks it high. Parsing happens upstream: the block receives a descriptor that already holds the ingress port, a tag-present flag, the tag's user priority, an IP-present flag and the codepoint.

The scheduler counts packets, not bytes. One setting gives strict priority to the high queue. The other three give a 2:1, 4:1 or 8:1 packet ratio between the queues while both hold traffic. A queue that is empty gives up its turn at once. The queue storage sits outside the block, which sees only the two non-empty flags and a request strobe.

Top module: `qos_wrr_sched`

## Requirements
- R1: While reset (rstN low) is applied, prioValid and grantValid are 0. After reset the internal high-run counter is zero, so the first weighted decision behaves as if no high frames had been served.
- R2: Port rule. portPriCfg=00 marks no port high. 01 marks ports 0 and 1 high, 10 marks ports 0 to 3 high, and 11 marks ports 0 to 7 high. The rule marks all other ports low.
- R3: Tag rule. When dot1pEn=1 and descTagged=1, user priority 4 to 7 (descUserPri[2]=1) marks the frame high and 0 to 3 does not. An untagged frame never becomes high by this rule.
- R4: Codepoint rule. When dsEn=1 and descIpValid=1, codepoints 101110, 001010, 010010, 011010, 100010, 110000 and 111000 (descDscp[5:0], MSB first) mark the frame high. Every other codepoint does not, and neither does a frame with descIpValid=0.
- R5: prioHigh is the OR of the enabled rules. A frame for which no enabled rule fires, such as an untagged non-IP frame from a port outside the range, is low.
- R6: prioValid is 1 exactly one cycle after a cycle with descValid=1, and prioHigh carries that frame's result.
- R7: With weightCfg=11, a request while the high queue is non-empty grants high, and a request with only the low queue non-empty grants low.
- R8: With weightCfg 00, 01 or 10, N is 2, 4 or 8 respectively. While both queues stay non-empty, the grants repeat as N high grants followed by one low grant. A low grant clears the run of high grants.
- R9: An empty queue gives up its turn. If only one queue is non-empty, a request grants that queue whatever the run count.
- R10: grantValid is 1 exactly one cycle after a cycle with grantReq=1 and at least one queue non-empty, and is 0 otherwise. The run count does not change without a grant.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| portPriCfg | input | 2 | Port-range priority setting |
| dot1pEn | input | 1 | Enable tag user-priority rule |
| dsEn | input | 1 | Enable codepoint rule |
| weightCfg | input | 2 | Scheduler mode: 11 strict, 10 8:1, 01 4:1, 00 2:1 |
| descValid | input | 1 | Frame descriptor present this cycle |
| descPort | input | PORT_W (4) | Ingress port of the frame |
| descTagged | input | 1 | Frame carries a VLAN tag |
| descUserPri | input | 3 | Tag user priority |
| descIpValid | input | 1 | Frame carries an IPv4/IPv6 header |
| descDscp | input | 6 | Differentiated-services codepoint |
| prioValid | output | 1 | Classification result valid |
| prioHigh | output | 1 | 1 = high priority |
| hiNotEmpty | input | 1 | High queue holds a frame |
| loNotEmpty | input | 1 | Low queue holds a frame |
| grantReq | input | 1 | Egress port ready for the next frame |
| grantValid | output | 1 | A grant was made |
| grantSelHigh | output | 1 | 1 = grant high queue, 0 = low queue |

## Verification
The classifier is first tried one rule at a time: every port under each range setting, every user priority tagged and untagged, and all 64 codepoints with and without an IP header. This separates a range off by one port, a wrong priority threshold and a missing or extra codepoint. Mixed random descriptors with random enables then test the OR and the default-low case. The scheduler runs with both queues held full under each weight, which exposes a wrong ratio or a counter that does not clear. It also runs with random empty flags and gaps in the requests, which shows whether an empty queue gives up its turn and whether the run count changes only on grants.

// File: rtl/qos_pkg.sv
package qos_pkg;
  localparam int CNT_W = 4;

  typedef struct packed {
    logic grant;
    logic selHigh;
    logic cntInc;
    logic cntClr;
  } schedStrb_t;

  function automatic logic dscpIsHigh(input logic [5:0] cp);
    logic hit;
    hit = 1'b0;
    unique case (cp)
      6'b101110, 6'b001010, 6'b010010, 6'b011010, 6'b100010: hit = 1'b1;
      default: hit = (cp[5:4] == 2'b11) && (cp[2:0] == 3'b000);
    endcase
    return hit;
  endfunction
endpackage

// File: rtl/qos_class.sv
module qos_class #(
  parameter int PORT_W = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [1:0]        portPriCfg,
  input  logic              dot1pEn,
  input  logic              dsEn,
  input  logic              descValid,
  input  logic [PORT_W-1:0] descPort,
  input  logic              descTagged,
  input  logic [2:0]        descUserPri,
  input  logic              descIpValid,
  input  logic [5:0]        descDscp,
  output logic              prioValid,
  output logic              prioHigh
);
  import qos_pkg::*;

  localparam int LIM_W = PORT_W + 2;

  logic [LIM_W-1:0] portLimit;
  logic portHit, tagHit, dsHit, anyHit;

  always_comb begin
    portLimit = '0;
    portLimit[portPriCfg] = 1'b1;
  end

  assign portHit = (portPriCfg != 2'b00) && ({2'b00, descPort} < portLimit);
  assign tagHit  = dot1pEn && descTagged && descUserPri[2];
  assign dsHit   = dsEn && descIpValid && dscpIsHigh(descDscp);
  assign anyHit  = portHit | tagHit | dsHit;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      prioValid <= 1'b0;
      prioHigh  <= 1'b0;
    end else begin
      prioValid <= descValid;
      if (descValid) prioHigh <= anyHit;
    end
  end
endmodule

// File: rtl/wrr_ctl.sv
module wrr_ctl (
  input  logic                 grantReq,
  input  logic                 hiNotEmpty,
  input  logic                 loNotEmpty,
  input  logic [1:0]           weightCfg,
  input  logic                 cntAtLimit,
  output qos_pkg::schedStrb_t  strb
);
  import qos_pkg::*;

  logic strictMode, pickHigh;

  assign strictMode = (weightCfg == 2'b11);

  always_comb begin
    if (strictMode) pickHigh = hiNotEmpty;
    else            pickHigh = hiNotEmpty && !(loNotEmpty && cntAtLimit);
  end

  always_comb begin
    strb         = '0;
    strb.grant   = grantReq && (hiNotEmpty || loNotEmpty);
    strb.selHigh = pickHigh;
    if (strb.grant) begin
      if (strictMode || !pickHigh) strb.cntClr = 1'b1;
      else                         strb.cntInc = 1'b1;
    end
  end
endmodule

// File: rtl/wrr_dp.sv
module wrr_dp (
  input  logic                clk,
  input  logic                rstN,
  input  logic [1:0]          weightCfg,
  input  qos_pkg::schedStrb_t strb,
  output logic                cntAtLimit,
  output logic                grantValid,
  output logic                grantSelHigh
);
  import qos_pkg::*;

  logic [CNT_W-1:0] hiRun;
  logic [CNT_W-1:0] runLimit;

  always_comb begin
    runLimit = '0;
    runLimit[weightCfg + 2'd1] = 1'b1;
  end

  assign cntAtLimit = (hiRun >= runLimit);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      hiRun        <= '0;
      grantValid   <= 1'b0;
      grantSelHigh <= 1'b0;
    end else begin
      grantValid <= strb.grant;
      if (strb.grant) grantSelHigh <= strb.selHigh;
      if (strb.cntClr)                    hiRun <= '0;
      else if (strb.cntInc && !cntAtLimit) hiRun <= hiRun + 1'b1;
    end
  end
endmodule

// File: rtl/qos_wrr_sched.sv
module qos_wrr_sched #(
  parameter int PORT_CNT = 16,
  parameter int PORT_W   = $clog2(PORT_CNT)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [1:0]        portPriCfg,
  input  logic              dot1pEn,
  input  logic              dsEn,
  input  logic [1:0]        weightCfg,
  input  logic              descValid,
  input  logic [PORT_W-1:0] descPort,
  input  logic              descTagged,
  input  logic [2:0]        descUserPri,
  input  logic              descIpValid,
  input  logic [5:0]        descDscp,
  output logic              prioValid,
  output logic              prioHigh,
  input  logic              hiNotEmpty,
  input  logic              loNotEmpty,
  input  logic              grantReq,
  output logic              grantValid,
  output logic              grantSelHigh
);
  import qos_pkg::*;

  schedStrb_t strb;
  logic cntAtLimit;

  qos_class #(.PORT_W(PORT_W)) u_class (
    .clk(clk), .rstN(rstN), .portPriCfg(portPriCfg), .dot1pEn(dot1pEn),
    .dsEn(dsEn), .descValid(descValid), .descPort(descPort),
    .descTagged(descTagged), .descUserPri(descUserPri),
    .descIpValid(descIpValid), .descDscp(descDscp),
    .prioValid(prioValid), .prioHigh(prioHigh)
  );

  wrr_ctl u_ctl (
    .grantReq(grantReq), .hiNotEmpty(hiNotEmpty), .loNotEmpty(loNotEmpty),
    .weightCfg(weightCfg), .cntAtLimit(cntAtLimit), .strb(strb)
  );

  wrr_dp u_dp (
    .clk(clk), .rstN(rstN), .weightCfg(weightCfg), .strb(strb),
    .cntAtLimit(cntAtLimit), .grantValid(grantValid),
    .grantSelHigh(grantSelHigh)
  );
endmodule

// File: rtl/qos_wrr_sched_chk.sv
module qos_wrr_sched_chk #(
  parameter int PORT_W = 4
) (
  input logic              clk,
  input logic              rstN,
  input logic [1:0]        portPriCfg,
  input logic              dot1pEn,
  input logic              dsEn,
  input logic [1:0]        weightCfg,
  input logic              descValid,
  input logic [PORT_W-1:0] descPort,
  input logic              descTagged,
  input logic [2:0]        descUserPri,
  input logic              descIpValid,
  input logic [5:0]        descDscp,
  input logic              prioValid,
  input logic              prioHigh,
  input logic              hiNotEmpty,
  input logic              loNotEmpty,
  input logic              grantReq,
  input logic              grantValid,
  input logic              grantSelHigh
);
  logic [3:0] runSeen;
  logic       strictAtReq;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      runSeen     <= '0;
      strictAtReq <= 1'b0;
    end else begin
      strictAtReq <= (weightCfg == 2'b11);
      if (grantValid) begin
        if (!grantSelHigh || strictAtReq) runSeen <= '0;
        else if (runSeen != 4'hF)         runSeen <= runSeen + 1'b1;
      end
    end
  end

  // R6
  a_r6_valid_follows: assert property (@(posedge clk) disable iff (!rstN)
    descValid |=> prioValid);
  a_r6_no_spurious: assert property (@(posedge clk) disable iff (!rstN)
    !descValid |=> !prioValid);
  // R3
  a_r3_tag_high: assert property (@(posedge clk) disable iff (!rstN)
    (descValid && dot1pEn && descTagged && descUserPri[2]) |=> prioHigh);
  // R5
  a_r5_all_off_low: assert property (@(posedge clk) disable iff (!rstN)
    (descValid && portPriCfg == 2'b00 && !dot1pEn && !dsEn) |=> !prioHigh);
  // R10
  a_r10_grant_when_asked: assert property (@(posedge clk) disable iff (!rstN)
    (grantReq && (hiNotEmpty || loNotEmpty)) |=> grantValid);
  a_r10_no_idle_grant: assert property (@(posedge clk) disable iff (!rstN)
    !(grantReq && (hiNotEmpty || loNotEmpty)) |=> !grantValid);
  // R9
  a_r9_only_low: assert property (@(posedge clk) disable iff (!rstN)
    (grantReq && !hiNotEmpty && loNotEmpty) |=> !grantSelHigh);
  a_r9_only_high: assert property (@(posedge clk) disable iff (!rstN)
    (grantReq && hiNotEmpty && !loNotEmpty) |=> grantSelHigh);
  // R7
  a_r7_strict_high: assert property (@(posedge clk) disable iff (!rstN)
    (grantReq && hiNotEmpty && weightCfg == 2'b11) |=> grantSelHigh);
  // R8
  a_r8_run_bound: assert property (@(posedge clk) disable iff (!rstN)
    (grantReq && loNotEmpty && weightCfg != 2'b11 && runSeen >= 4'd8 && !grantValid)
      |=> !grantSelHigh);
endmodule

bind qos_wrr_sched qos_wrr_sched_chk #(.PORT_W(PORT_W)) u_chk (.*);

// File: tb/tb_qos_wrr_sched.sv
module tb_qos_wrr_sched;
  localparam int CLK_PERIOD = 10;
  localparam int PORT_W = 4;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic [1:0] portPriCfg = '0, weightCfg = 2'b11;
  logic dot1pEn = 0, dsEn = 0, descValid = 0, descTagged = 0, descIpValid = 0;
  logic [PORT_W-1:0] descPort = '0;
  logic [2:0] descUserPri = '0;
  logic [5:0] descDscp = '0;
  logic hiNotEmpty = 0, loNotEmpty = 0, grantReq = 0;
  logic prioValid, prioHigh, grantValid, grantSelHigh;

  int vectors = 0, fails = 0, cycles = 0;
  string curReq = "R1";

  logic expPV = 0, expPH = 0, expGV = 0, expGS = 0;
  int run = 0;

  qos_wrr_sched dut (.*);

  always #(CLK_PERIOD/2) clk = ~clk;

  function automatic bit modelHigh();
    bit h = 0;
    case (portPriCfg)
      2'b01: h = (descPort <= 1);
      2'b10: h = (descPort <= 3);
      2'b11: h = (descPort <= 7);
      default: h = 0;
    endcase
    if (dot1pEn && descTagged && descUserPri >= 4) h = 1;
    if (dsEn && descIpValid &&
        (descDscp == 6'd46 || descDscp == 6'd10 || descDscp == 6'd18 ||
         descDscp == 6'd26 || descDscp == 6'd34 || descDscp == 6'd48 ||
         descDscp == 6'd56)) h = 1;
    return h;
  endfunction

  // behavioural reference, evaluated at each rising edge
  always @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      expPV = 0; expPH = 0; expGV = 0; expGS = 0; run = 0;
    end else begin
      int n;
      expPV = descValid;
      if (descValid) expPH = modelHigh();
      expGV = grantReq && (hiNotEmpty || loNotEmpty);
      if (expGV) begin
        if (weightCfg == 2'b11) begin
          expGS = hiNotEmpty; run = 0;
        end else begin
          n = 2 << weightCfg;
          if (loNotEmpty && (!hiNotEmpty || run >= n)) begin
            expGS = 0; run = 0;
          end else begin
            expGS = 1; if (run < n) run = run + 1;
          end
        end
      end
    end
  end

  task automatic check1(input string what, input logic act, input logic exp);
    vectors++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s: actual %0b expected %0b at cycle %0d", curReq, what, act, exp, cycles);
    end
  endtask

  // compare on every falling edge
  always @(negedge clk) begin
    cycles++;
    check1("prioValid", prioValid, expPV);
    if (expPV) check1("prioHigh", prioHigh, expPH);
    check1("grantValid", grantValid, expGV);
    if (expGV) check1("grantSelHigh", grantSelHigh, expGS);
  end

  task automatic step();
    @(negedge clk);
    #1;
  endtask

  task automatic sendDesc(input int port, input bit tg, input int up, input bit ip, input int cp);
    descValid = 1; descPort = port[PORT_W-1:0]; descTagged = tg;
    descUserPri = up[2:0]; descIpValid = ip; descDscp = cp[5:0];
    step();
    descValid = 0;
  endtask

  initial begin
    // R1: reset state
    step();
    check1("reset prioValid", prioValid, 1'b0);
    check1("reset grantValid", grantValid, 1'b0);
    rstN = 1;
    step();

    // R2: port ranges
    curReq = "R2";
    for (int c = 0; c < 4; c++) begin
      portPriCfg = c[1:0];
      for (int p = 0; p < 16; p++) sendDesc(p, 0, 0, 0, 0);
    end
    portPriCfg = 0;

    // R3: tag priority, tagged and untagged
    curReq = "R3";
    dot1pEn = 1;
    for (int u = 0; u < 8; u++) begin
      sendDesc(12, 1, u, 0, 0);
      sendDesc(12, 0, u, 0, 0);
    end
    dot1pEn = 0;
    sendDesc(12, 1, 7, 0, 0);

    // R4: every codepoint, with and without IP
    curReq = "R4";
    dsEn = 1;
    for (int d = 0; d < 64; d++) begin
      sendDesc(9, 0, 0, 1, d);
      sendDesc(9, 0, 0, 0, d);
    end
    dsEn = 0;
    sendDesc(9, 0, 0, 1, 46);

    // R5/R6: mixed sources, gaps between descriptors; untagged non-IP default low
    curReq = "R5";
    sendDesc(15, 0, 7, 0, 46);
    for (int i = 0; i < 400; i++) begin
      portPriCfg = $urandom_range(0, 3);
      dot1pEn = $urandom_range(0, 1);
      dsEn = $urandom_range(0, 1);
      curReq = (i % 2) ? "R5" : "R6";
      if ($urandom_range(0, 3) == 0) step();
      else sendDesc($urandom_range(0, 15), $urandom_range(0, 1), $urandom_range(0, 7),
                    $urandom_range(0, 1), $urandom_range(0, 63));
    end

    // R7: strict mode
    curReq = "R7";
    weightCfg = 2'b11; grantReq = 1;
    for (int i = 0; i < 60; i++) begin
      hiNotEmpty = $urandom_range(0, 1); loNotEmpty = $urandom_range(0, 1);
      step();
    end

    // R8: both backlogged, each weight
    curReq = "R8";
    hiNotEmpty = 1; loNotEmpty = 1;
    for (int w = 0; w < 3; w++) begin
      weightCfg = w[1:0];
      for (int i = 0; i < 40; i++) step();
    end

    // R9: random empties, forfeited turns
    curReq = "R9";
    for (int i = 0; i < 600; i++) begin
      weightCfg = (i < 300) ? 2'b10 : $urandom_range(0, 3);
      hiNotEmpty = $urandom_range(0, 3) != 0;
      loNotEmpty = $urandom_range(0, 2) == 0;
      step();
    end

    // R10: no request or nothing queued leaves run unchanged
    curReq = "R10";
    weightCfg = 2'b00;
    for (int i = 0; i < 300; i++) begin
      grantReq = $urandom_range(0, 1);
      hiNotEmpty = $urandom_range(0, 1); loNotEmpty = $urandom_range(0, 1);
      step();
    end
    grantReq = 0; hiNotEmpty = 0; loNotEmpty = 0;
    step(); step();

    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 100000);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end
endmodule